// File: doc/BRIEF.md
# Backtracking Step-Length Search Unit

This block picks the step length for one iteration of an interior-point solver that has only bound constraints on its inputs. After the solver has a search direction, the unit is started with the length of the combined slack and multiplier vector. It then reads pairs of current value and direction from a block RAM, one element per cycle. It tests candidate steps 1, 1/2, 1/4 and so on. A candidate passes only when every updated element stays strictly above zero. The first candidate that passes is reported as a shift count.

Each candidate is a power of two, so scaling a direction is an arithmetic right shift and needs no multiplier. The scan of a candidate stops at the first element that goes non-positive, and the next halving starts again from element zero. After seventeen halvings the unit stops and reports a zero step. This gives a hard upper bound on the cycles the search can take.

Top module: `slk_step_search`

## Requirements
- R1: A candidate with shift k passes only when, for every element, cur + (dir >>> k) is strictly greater than zero. Here >>> is an arithmetic right shift of the signed DATA_W-bit direction, and the sum is formed one bit wider so that it never wraps.
- R2: Candidates are tried in the order k = 0, 1, 2, and so on. The reported step_shift is the smallest k that passes, with step_zero low.
- R3: If every k from 0 to MAX_HALV (17) fails, done is raised with step_zero high and step_shift equal to 0. step_shift never exceeds MAX_HALV.
- R4: Reads use a one-cycle RAM latency. rd_en is asserted with rd_addr in the same cycle, and rd_cur/rd_dir carry that element one cycle later. Addresses are always below the latched length, and rd_en is low while no search runs.
- R5: A start is captured at a clock edge. A rejected candidate whose first failing element is index j costs j+2 cycles. The accepted candidate costs n+1 cycles. done is high exactly after the edge that ends this total.
- R6: done is a single-cycle pulse. step_shift and step_zero keep their values until the next done.
- R7: A start that arrives while a search is running is ignored, together with its length. The running search keeps its timing and result.
- R8: A length of zero accepts the full step (step_shift 0, step_zero 0), with done one cycle after the start.
- R9: During and right after reset, done, step_zero, step_shift and rd_en are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, taken only when idle |
| vec_len | input | ADDR_W+1 | Number of elements to test, captured with start |
| rd_en | output | 1 | RAM read enable |
| rd_addr | output | ADDR_W | RAM read address |
| rd_cur | input | DATA_W | Current slack or multiplier value, one cycle after the read |
| rd_dir | input | DATA_W | Search-direction value, one cycle after the read |
| done | output | 1 | One-cycle pulse when the result is ready |
| step_shift | output | $clog2(MAX_HALV+1) | Accepted step as a right-shift count |
| step_zero | output | 1 | High when every halving failed and the step is zero |

## Verification
Most internal faults change the timing of done, because the unit's latency is the sum of the per-candidate scan costs. A wrong halving counter, a stale read that is not cancelled after a rejection, or a scan that does not restart at element zero therefore moves done by at least one cycle. That shift shows up in the first search that rejects a candidate. Errors in the sign, width or strictness of the positivity test show up as a different step_shift or step_zero when done is raised. The cases that expose them are elements that land exactly on zero, sums that would wrap at DATA_W bits, and a step that is accepted only at the last halving.

// File: rtl/slk_pkg.sv
package slk_pkg;

  typedef enum logic {
    SLK_IDLE = 1'b0,
    SLK_SCAN = 1'b1
  } slk_state_e;

endpackage

// File: rtl/slk_shift_test.sv
module slk_shift_test #(
  parameter int DATA_W = 24,
  parameter int K_W    = 5
) (
  input  logic signed [DATA_W-1:0] cur,
  input  logic signed [DATA_W-1:0] dir,
  input  logic        [K_W-1:0]    k,
  output logic                     pass
);

  logic signed [DATA_W-1:0] scaled;
  logic        [DATA_W:0]   sum;

  // scale by 2^-k, rounding toward minus infinity
  assign scaled = dir >>> k;
  // one extra bit so the sum never wraps
  assign sum  = {cur[DATA_W-1], cur} + {scaled[DATA_W-1], scaled};
  assign pass = !sum[DATA_W] && (sum != '0);

endmodule

// File: rtl/slk_elem_fetch.sv
module slk_elem_fetch #(
  parameter int ADDR_W = 6,
  parameter int LEN_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              restart,
  input  logic [LEN_W-1:0]  len,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              chk_valid,
  output logic              chk_last
);

  logic [LEN_W-1:0] idx;
  logic             issue;

  assign issue   = run && (idx < len);
  assign rd_en   = issue;
  assign rd_addr = idx[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      idx       <= '0;
      chk_valid <= 1'b0;
      chk_last  <= 1'b0;
    end else if (restart) begin
      // drop the read in flight, rescan from element zero
      idx       <= '0;
      chk_valid <= 1'b0;
      chk_last  <= 1'b0;
    end else begin
      idx       <= idx + LEN_W'(issue);
      chk_valid <= issue;
      chk_last  <= issue && (idx == len - LEN_W'(1));
    end
  end

  AST_READ_BOUND: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> ({1'b0, rd_addr} < len)); // R4
  AST_NO_READ_IDLE: assert property (@(posedge clk) disable iff (rst)
    !run |-> !rd_en); // R4
  AST_DATA_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    chk_valid |-> $past(rd_en)); // R4

endmodule

// File: rtl/slk_halving_ctrl.sv
module slk_halving_ctrl
  import slk_pkg::*;
#(
  parameter int MAX_HALV = 17,
  parameter int LEN_W    = 7,
  parameter int K_W      = $clog2(MAX_HALV + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] len_in,
  input  logic             chk_valid,
  input  logic             chk_last,
  input  logic             chk_pass,
  output logic             run,
  output logic             restart,
  output logic [LEN_W-1:0] len_q,
  output logic [K_W-1:0]   k,
  output logic             done,
  output logic [K_W-1:0]   step_shift,
  output logic             step_zero
);

  localparam logic [K_W-1:0] K_LAST = K_W'(MAX_HALV);

  slk_state_e state;
  logic       fail;
  logic       give_up;
  logic       accept;

  assign run     = (state == SLK_SCAN);
  assign fail    = run && chk_valid && !chk_pass;
  assign restart = fail && (k != K_LAST);
  assign give_up = fail && (k == K_LAST);
  assign accept  = run && ((chk_valid && chk_pass && chk_last) || (len_q == '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SLK_IDLE;
      len_q      <= '0;
      k          <= '0;
      done       <= 1'b0;
      step_shift <= '0;
      step_zero  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        SLK_IDLE: begin
          if (start) begin
            state <= SLK_SCAN;
            len_q <= len_in;
            k     <= '0;
          end
        end
        SLK_SCAN: begin
          if (accept) begin
            state      <= SLK_IDLE;
            done       <= 1'b1;
            step_shift <= k;
            step_zero  <= 1'b0;
          end else if (give_up) begin
            state      <= SLK_IDLE;
            done       <= 1'b1;
            step_shift <= '0;
            step_zero  <= 1'b1;
          end else if (restart) begin
            k <= k + K_W'(1);
          end
        end
        default: state <= SLK_IDLE;
      endcase
    end
  end

  AST_K_LIMIT: assert property (@(posedge clk) disable iff (rst)
    k <= K_LAST); // R3
  AST_K_NO_DECREASE: assert property (@(posedge clk) disable iff (rst)
    run |=> (!run || (k >= $past(k)))); // R2
  AST_ZERO_CODE: assert property (@(posedge clk) disable iff (rst)
    step_zero |-> (step_shift == '0)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (run && start) |=> $stable(len_q)); // R7
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    !done |=> (done || ($stable(step_shift) && $stable(step_zero)))); // R6

endmodule

// File: rtl/slk_step_search.sv
module slk_step_search #(
  parameter int DATA_W   = 24,
  parameter int ADDR_W   = 6,
  parameter int MAX_HALV = 17,
  localparam int LEN_W   = ADDR_W + 1,
  localparam int K_W     = $clog2(MAX_HALV + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [LEN_W-1:0]         vec_len,
  output logic                     rd_en,
  output logic [ADDR_W-1:0]        rd_addr,
  input  logic signed [DATA_W-1:0] rd_cur,
  input  logic signed [DATA_W-1:0] rd_dir,
  output logic                     done,
  output logic [K_W-1:0]           step_shift,
  output logic                     step_zero
);

  logic             run;
  logic             restart;
  logic [LEN_W-1:0] len_q;
  logic [K_W-1:0]   k;
  logic             chk_valid;
  logic             chk_last;
  logic             chk_pass;

  slk_halving_ctrl #(
    .MAX_HALV (MAX_HALV),
    .LEN_W    (LEN_W),
    .K_W      (K_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .len_in     (vec_len),
    .chk_valid  (chk_valid),
    .chk_last   (chk_last),
    .chk_pass   (chk_pass),
    .run        (run),
    .restart    (restart),
    .len_q      (len_q),
    .k          (k),
    .done       (done),
    .step_shift (step_shift),
    .step_zero  (step_zero)
  );

  slk_elem_fetch #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W)
  ) u_fetch (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .restart   (restart),
    .len       (len_q),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .chk_valid (chk_valid),
    .chk_last  (chk_last)
  );

  slk_shift_test #(
    .DATA_W (DATA_W),
    .K_W    (K_W)
  ) u_test (
    .cur  (rd_cur),
    .dir  (rd_dir),
    .k    (k),
    .pass (chk_pass)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!done && !step_zero && (step_shift == '0))); // R9

endmodule

// File: tb/test_slk_step_search.sv
`timescale 1ns/1ps
module test_slk_step_search;

  localparam int DATA_W   = 24;
  localparam int ADDR_W   = 6;
  localparam int MAX_HALV = 17;
  localparam int LEN_W    = ADDR_W + 1;
  localparam int K_W      = $clog2(MAX_HALV + 1);
  localparam int DEPTH    = 1 << ADDR_W;

  logic                     clk = 1'b0;
  logic                     rst = 1'b1;
  logic                     start = 1'b0;
  logic [LEN_W-1:0]         vec_len = '0;
  logic                     rd_en;
  logic [ADDR_W-1:0]        rd_addr;
  logic signed [DATA_W-1:0] rd_cur;
  logic signed [DATA_W-1:0] rd_dir;
  logic                     done;
  logic [K_W-1:0]           step_shift;
  logic                     step_zero;

  logic signed [DATA_W-1:0] mem_v [DEPTH];
  logic signed [DATA_W-1:0] mem_d [DEPTH];

  int nchk = 0;
  int nerr = 0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (rd_en) begin
      rd_cur <= mem_v[rd_addr];
      rd_dir <= mem_d[rd_addr];
    end
  end

  slk_step_search #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .MAX_HALV (MAX_HALV)
  ) i_slk_step_search (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .vec_len    (vec_len),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_cur     (rd_cur),
    .rd_dir     (rd_dir),
    .done       (done),
    .step_shift (step_shift),
    .step_zero  (step_zero)
  );

  task automatic chk(string req, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural model: expected shift, zero flag and latency in edges
  function automatic void ref_model(input int n, output int ek, output int ez, output int ed);
    ek = 0; ez = 0; ed = 0;
    if (n == 0) begin
      ed = 1;
      return;
    end
    for (int k = 0; k <= MAX_HALV; k++) begin
      int first_bad = -1;
      for (int j = 0; j < n; j++) begin
        int cv = mem_v[j];
        int dv = mem_d[j];
        if (cv + (dv >>> k) <= 0) begin
          first_bad = j;
          break;
        end
      end
      if (first_bad < 0) begin
        ek = k;
        ed += n + 1;
        return;
      end
      ed += first_bad + 2;
    end
    ek = 0;
    ez = 1;
  endfunction

  task automatic fill(int n, int v, int d);
    for (int i = 0; i < n; i++) begin
      mem_v[i] = DATA_W'(v);
      mem_d[i] = DATA_W'(d);
    end
  endtask

  task automatic run_case(string req, int n, int poke);
    int ek, ez, ed;
    ref_model(n, ek, ez, ed);
    @(negedge clk);
    start   = 1'b1;
    vec_len = LEN_W'(n);
    for (int c = 0; c <= ed + 1; c++) begin
      @(negedge clk);
      if (c == ed) begin
        chk("R5", {req, " done at expected cycle"}, int'(done), 1);
        chk(req, "step_shift", int'(step_shift), ek);
        chk(req, "step_zero", int'(step_zero), ez);
      end else begin
        chk("R6", {req, " done low outside its cycle"}, int'(done), 0);
      end
      if (c == ed + 1) begin
        chk("R6", {req, " shift held"}, int'(step_shift), ek);
        chk("R7", {req, " no search after done"}, int'(rd_en), 0);
      end
      if (rd_en) chk("R4", {req, " address in range"}, int'(rd_addr < n), 1);
      if (c == poke) begin
        start   = 1'b1;
        vec_len = LEN_W'(1);
      end else begin
        start   = 1'b0;
        vec_len = LEN_W'(n);
      end
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    fill(DEPTH, 1, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9", "done in reset", int'(done), 0);
    chk("R9", "rd_en in reset", int'(rd_en), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9", "done after reset", int'(done), 0);
    chk("R9", "step_zero after reset", int'(step_zero), 0);
    chk("R9", "step_shift after reset", int'(step_shift), 0);
    chk("R9", "rd_en after reset", int'(rd_en), 0);

    // R2: all directions positive, full step
    fill(8, 100, 5);
    run_case("R2", 8, -1);

    // R2: one halving needed
    fill(4, 10, -15);
    run_case("R2", 4, -1);

    // R1: exact zero is rejected, k=4
    fill(3, 5, -40);
    run_case("R1", 3, -1);

    // R3: accepted only at the last halving
    fill(2, 2, -131072);
    run_case("R3", 2, -1);

    // R3: nothing passes, zero step
    fill(2, 2, -262144);
    run_case("R3", 2, -1);

    // R3: value already zero never passes
    fill(1, 0, 0);
    run_case("R3", 1, -1);

    // R1: sum beyond DATA_W must not wrap
    fill(3, 8388607, 8388607);
    run_case("R1", 3, -1);

    // R8: empty vector
    run_case("R8", 0, -1);

    // R5: failure at the last element
    fill(10, 50, 3);
    mem_v[9] = 3; mem_d[9] = -7;
    run_case("R5", 10, -1);

    // R5: mixed elements failing at different indices
    fill(6, 40, -10);
    mem_v[0] = 50; mem_d[0] = -60;
    mem_v[4] = 4;  mem_d[4] = -64;
    run_case("R5", 6, -1);

    // R7: start during the same search is ignored
    run_case("R7", 6, 3);

    // R4: full-length vector
    fill(DEPTH, 7, -1);
    run_case("R4", DEPTH, -1);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule